// File: doc/BRIEF.md
# Program-Flow Discontinuity Recorder

This block keeps a short history of where program flow broke its sequence. It does not log every retired instruction. Each time the core signals a taken branch, jump or exception, the block stores one record in a circular buffer. The record holds the retiring (source) PC, the destination PC and the number of clock cycles since the previous record. That cycle count is the real elapsed time, so stalls from caches or the pipeline appear in it. Once the buffer is full, each new record replaces the oldest one, so the buffer always holds the latest jumps.

A breakpoint drives the freeze input. While freeze is high, nothing new is captured, so the jumps that led into an invalid region remain in the buffer. Software then reads the records through an index port, oldest first, for example to copy them to non-volatile memory. A clear command empties the buffer. Capture starts again when freeze is released.

Top module: `disc_trace_buf`

## Requirements
- R1: When `disc_i` is high, `freeze_i` is low and `clr_i` is low in a cycle, one record is appended with source = `pc_i`, destination = `tgt_i` and the current cycle delta.
- R2: The delta of a record equals 1 plus the number of non-frozen cycles strictly between it and the previous record, or between it and the last clear. Two back-to-back records after a clear both carry delta 1.
- R3: The delta counter saturates at 2^CNT_W-1 (4095 by default) instead of wrapping.
- R4: The buffer holds DEPTH (16, a power of two) records. `count_o` rises by one per record up to DEPTH and then stays there, while each further record overwrites the oldest.
- R5: Read index 0 returns the oldest valid record and index `count_o`-1 the newest. `rd_valid_o` is 1 exactly when `rd_idx_i` < `count_o`. Reading never changes the contents or the count.
- R6: While `freeze_i` is high, strobes are ignored, the stored records and count stay unchanged, and the delta counter does not advance.
- R7: `clr_i` sets `count_o` to 0 and restarts the delta counter. If `clr_i` and a strobe arrive in the same cycle, the clear wins and no record is made.
- R8: After reset, `count_o` is 0 and `rd_valid_o` is 0 for every index.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| pc_i | input | PC_W | Retiring PC, taken as the source address |
| disc_i | input | 1 | Discontinuity strobe |
| tgt_i | input | PC_W | Destination PC of the discontinuity |
| freeze_i | input | 1 | Halts capture (breakpoint hit) |
| clr_i | input | 1 | Empties the buffer and restarts the delta counter |
| rd_idx_i | input | $clog2(DEPTH) | Read index, 0 = oldest |
| rd_src_o | output | PC_W | Source PC of the indexed record |
| rd_dst_o | output | PC_W | Destination PC of the indexed record |
| rd_delta_o | output | CNT_W | Cycle delta of the indexed record |
| rd_valid_o | output | 1 | Index is below the valid count |
| count_o | output | $clog2(DEPTH+1) | Number of valid records |

## Verification
A strobe can land in the same cycle as a clear, and it can also land while freeze is high. Both cases decide whether a record is written. The bench raises `disc_i` in the same cycle as `clr_i` and checks that `count_o` is 0 afterwards and that the next record has a delta of 1. It also pulses strobes during a freeze and checks that the count and the readable contents do not change. The first record after the freeze is then checked: its delta must leave out the frozen cycles.

// File: rtl/dtb_pkg.sv
package dtb_pkg;
    localparam int DEF_PC_W  = 32;
    localparam int DEF_CNT_W = 12;
    localparam int DEF_DEPTH = 16;
endpackage

// File: rtl/dtb_cyc_ctr.sv
module dtb_cyc_ctr #(
    parameter int CNT_W = 12
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run_i,
    input  logic             evt_i,
    input  logic             clr_i,
    output logic [CNT_W-1:0] cnt_o
);
    localparam logic [CNT_W-1:0] MAXV = {CNT_W{1'b1}};

    typedef struct packed {
        logic [CNT_W-1:0] cnt;
    } st_t;

    st_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (clr_i || evt_i) begin
            st_d.cnt = CNT_W'(1);
        end else if (run_i && st_q.cnt != MAXV) begin
            st_d.cnt = st_q.cnt + CNT_W'(1);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign cnt_o = st_q.cnt;

    // R3: the counter stays at its ceiling
    a_r3_saturates: assert property (@(posedge clk) disable iff (!rst_n)
        (run_i && !evt_i && !clr_i && cnt_o == MAXV) |=> cnt_o == MAXV);
    // R2: the counter restarts after a record or a clear
    a_r2_restart: assert property (@(posedge clk) disable iff (!rst_n)
        (evt_i || clr_i) |=> cnt_o == CNT_W'(1));
    // R6: the counter pauses while frozen
    a_r6_pause: assert property (@(posedge clk) disable iff (!rst_n)
        (!run_i && !evt_i && !clr_i) |=> $stable(cnt_o));
endmodule

// File: rtl/dtb_store.sv
module dtb_store #(
    parameter int PC_W  = 32,
    parameter int CNT_W = 12,
    parameter int DEPTH = 16
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       wr_i,
    input  logic                       clr_i,
    input  logic [PC_W-1:0]            src_i,
    input  logic [PC_W-1:0]            dst_i,
    input  logic [CNT_W-1:0]           delta_i,
    input  logic [$clog2(DEPTH)-1:0]   rd_idx_i,
    output logic [PC_W-1:0]            rd_src_o,
    output logic [PC_W-1:0]            rd_dst_o,
    output logic [CNT_W-1:0]           rd_delta_o,
    output logic                       rd_valid_o,
    output logic [$clog2(DEPTH+1)-1:0] count_o
);
    localparam int IDX_W = $clog2(DEPTH);
    localparam int CW    = $clog2(DEPTH+1);
    localparam int EW    = 2*PC_W + CNT_W;
    localparam logic [CW-1:0] FULL = CW'(DEPTH);

    typedef struct packed {
        logic [DEPTH-1:0][EW-1:0] mem;
        logic [IDX_W-1:0]         wptr;
        logic [CW-1:0]            cnt;
    } st_t;

    st_t st_d, st_q;
    logic [IDX_W-1:0] phys;
    logic [EW-1:0]    rd_ent;

    always_comb begin
        st_d = st_q;
        if (clr_i) begin
            st_d.wptr = '0;
            st_d.cnt  = '0;
        end else if (wr_i) begin
            st_d.mem[st_q.wptr] = {src_i, dst_i, delta_i};
            st_d.wptr = st_q.wptr + IDX_W'(1);
            if (st_q.cnt != FULL) st_d.cnt = st_q.cnt + CW'(1);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    // oldest record sits count places behind the write pointer
    always_comb begin
        phys   = st_q.wptr - IDX_W'(st_q.cnt) + rd_idx_i;
        rd_ent = st_q.mem[phys];
    end

    assign rd_src_o   = rd_ent[EW-1 -: PC_W];
    assign rd_dst_o   = rd_ent[CNT_W +: PC_W];
    assign rd_delta_o = rd_ent[CNT_W-1:0];
    assign rd_valid_o = CW'(rd_idx_i) < st_q.cnt;
    assign count_o    = st_q.cnt;

    // R4: count never exceeds the depth
    a_r4_bounded: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.cnt <= FULL);
    // R4: a full buffer stays full while records keep arriving
    a_r4_full_holds: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.cnt == FULL && wr_i && !clr_i) |=> st_q.cnt == FULL);
    // R1: each write advances the pointer by one
    a_r1_ptr_step: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_i && !clr_i) |=> st_q.wptr == $past(st_q.wptr) + IDX_W'(1));
endmodule

// File: rtl/disc_trace_buf.sv
module disc_trace_buf #(
    parameter int PC_W  = dtb_pkg::DEF_PC_W,
    parameter int CNT_W = dtb_pkg::DEF_CNT_W,
    parameter int DEPTH = dtb_pkg::DEF_DEPTH
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic [PC_W-1:0]            pc_i,
    input  logic                       disc_i,
    input  logic [PC_W-1:0]            tgt_i,
    input  logic                       freeze_i,
    input  logic                       clr_i,
    input  logic [$clog2(DEPTH)-1:0]   rd_idx_i,
    output logic [PC_W-1:0]            rd_src_o,
    output logic [PC_W-1:0]            rd_dst_o,
    output logic [CNT_W-1:0]           rd_delta_o,
    output logic                       rd_valid_o,
    output logic [$clog2(DEPTH+1)-1:0] count_o
);
    logic             rec;
    logic [CNT_W-1:0] delta;

    // clear outranks a strobe; freeze masks it
    assign rec = disc_i && !freeze_i && !clr_i;

    dtb_cyc_ctr #(.CNT_W(CNT_W)) u_ctr (
        .clk   (clk),
        .rst_n (rst_n),
        .run_i (!freeze_i),
        .evt_i (rec),
        .clr_i (clr_i),
        .cnt_o (delta)
    );

    dtb_store #(.PC_W(PC_W), .CNT_W(CNT_W), .DEPTH(DEPTH)) u_store (
        .clk        (clk),
        .rst_n      (rst_n),
        .wr_i       (rec),
        .clr_i      (clr_i),
        .src_i      (pc_i),
        .dst_i      (tgt_i),
        .delta_i    (delta),
        .rd_idx_i   (rd_idx_i),
        .rd_src_o   (rd_src_o),
        .rd_dst_o   (rd_dst_o),
        .rd_delta_o (rd_delta_o),
        .rd_valid_o (rd_valid_o),
        .count_o    (count_o)
    );

    // R6: frozen cycles leave the count untouched
    a_r6_freeze_holds: assert property (@(posedge clk) disable iff (!rst_n)
        (freeze_i && !clr_i) |=> $stable(count_o));
    // R7: clear empties the buffer
    a_r7_clear_empties: assert property (@(posedge clk) disable iff (!rst_n)
        clr_i |=> count_o == '0);
    // R5: valid flag agrees with the count
    a_r5_valid_range: assert property (@(posedge clk) disable iff (!rst_n)
        (count_o == '0) |-> !rd_valid_o);
endmodule

// File: tb/disc_trace_buf_tb.sv
module disc_trace_buf_tb;
    localparam int CLK_P = 10;
    localparam int PC_W = 32, CNT_W = 12, DEPTH = 16;

    logic clk = 0, rst_n = 0;
    logic [PC_W-1:0] pc_i = '0, tgt_i = '0;
    logic disc_i = 0, freeze_i = 0, clr_i = 0;
    logic [3:0] rd_idx_i = '0;
    logic [PC_W-1:0] rd_src_o, rd_dst_o;
    logic [CNT_W-1:0] rd_delta_o;
    logic rd_valid_o;
    logic [4:0] count_o;

    int errors = 0, checks = 0;
    logic [PC_W-1:0] e_src[DEPTH], e_dst[DEPTH];
    int e_dl[DEPTH];
    int e_n = 0;

    always #(CLK_P/2) clk = ~clk;

    disc_trace_buf u_dut (.*);

    task automatic tick(int n = 1);
        for (int i = 0; i < n; i++) begin @(posedge clk); #1; end
    endtask

    task automatic chk(bit ok, string req, string what, longint act, longint exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    task automatic push(logic [PC_W-1:0] s, logic [PC_W-1:0] d, int dl);
        if (e_n == DEPTH) begin
            for (int i = 0; i < DEPTH-1; i++) begin
                e_src[i] = e_src[i+1]; e_dst[i] = e_dst[i+1]; e_dl[i] = e_dl[i+1];
            end
            e_n--;
        end
        e_src[e_n] = s; e_dst[e_n] = d; e_dl[e_n] = dl; e_n++;
    endtask

    task automatic strobe(logic [PC_W-1:0] s, logic [PC_W-1:0] d);
        pc_i = s; tgt_i = d; disc_i = 1; tick(); disc_i = 0;
    endtask

    task automatic do_clear();
        clr_i = 1; tick(); clr_i = 0; e_n = 0;
    endtask

    task automatic check_all(string req);
        chk(count_o == 5'(e_n), req, "count", count_o, e_n);
        for (int i = 0; i < e_n; i++) begin
            rd_idx_i = 4'(i); #1;
            chk(rd_valid_o == 1'b1, req, "valid", rd_valid_o, 1);
            chk(rd_src_o == e_src[i], req, "src", rd_src_o, e_src[i]);
            chk(rd_dst_o == e_dst[i], req, "dst", rd_dst_o, e_dst[i]);
            chk(rd_delta_o == 12'(e_dl[i]), req, "delta", rd_delta_o, e_dl[i]);
        end
    endtask

    task automatic t_reset();
        chk(count_o == 0, "R8", "count after reset", count_o, 0);
        for (int i = 0; i < DEPTH; i += 5) begin
            rd_idx_i = 4'(i); #1;
            chk(rd_valid_o == 0, "R8", "valid after reset", rd_valid_o, 0);
        end
    endtask

    task automatic t_basic();
        do_clear();
        strobe(32'h1000, 32'h2000); push(32'h1000, 32'h2000, 1);
        tick(2);
        strobe(32'h1010, 32'h3000); push(32'h1010, 32'h3000, 3);
        tick(5);
        strobe(32'h3008, 32'h0400); push(32'h3008, 32'h0400, 6);
        check_all("R1/R2");
        rd_idx_i = 4'd3; #1;
        chk(rd_valid_o == 0, "R5", "valid beyond count", rd_valid_o, 0);
    endtask

    task automatic t_wrap();
        do_clear();
        for (int i = 0; i < 20; i++) begin
            strobe(PC_W'(32'h100 + i), PC_W'(32'h200 + i));
            push(PC_W'(32'h100 + i), PC_W'(32'h200 + i), 1);
        end
        check_all("R4");
        rd_idx_i = 4'd0; #1;
        chk(rd_src_o == 32'h104, "R4", "oldest after wrap", rd_src_o, 32'h104);
    endtask

    task automatic t_read_stable();
        logic [PC_W-1:0] a;
        rd_idx_i = 4'd7; #1; a = rd_src_o;
        tick(3);
        rd_idx_i = 4'd2; #1; rd_idx_i = 4'd7; #1;
        chk(rd_src_o == a, "R5", "reread unchanged", rd_src_o, a);
        check_all("R5");
    endtask

    task automatic t_freeze();
        int n0;
        do_clear();
        strobe(32'hA0, 32'hB0); push(32'hA0, 32'hB0, 1);
        freeze_i = 1;
        for (int i = 0; i < 4; i++) strobe(PC_W'(32'hDEAD + i), 32'hBEEF);
        n0 = e_n;
        chk(count_o == 5'(n0), "R6", "count while frozen", count_o, n0);
        check_all("R6");
        freeze_i = 0;
        tick();
        strobe(32'hC0, 32'hD0); push(32'hC0, 32'hD0, 2);
        check_all("R6 delta excludes frozen");
    endtask

    task automatic t_clear_collide();
        strobe(32'h11, 32'h22);
        pc_i = 32'h33; tgt_i = 32'h44; disc_i = 1; clr_i = 1; tick();
        disc_i = 0; clr_i = 0; e_n = 0;
        chk(count_o == 0, "R7", "clear beats strobe", count_o, 0);
        strobe(32'h55, 32'h66); push(32'h55, 32'h66, 1);
        check_all("R7");
    endtask

    task automatic t_saturate();
        do_clear();
        strobe(32'h1, 32'h2); push(32'h1, 32'h2, 1);
        tick(5000);
        strobe(32'h3, 32'h4); push(32'h3, 32'h4, 4095);
        check_all("R3");
    endtask

    initial begin
        fork
            begin
                #1; tick(2); rst_n = 1; tick();
                t_reset();
                t_basic();
                t_wrap();
                t_read_stable();
                t_freeze();
                t_clear_collide();
                t_saturate();
            end
            begin
                #(CLK_P * 100000);
                errors++; checks++;
                $display("FAIL watchdog: actual=timeout expected=done");
            end
        join_any
        disable fork;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule